// File: doc/BRIEF.md
# 8-bit Timer/Counter with Compare Output and PWM

This block is an 8-bit counter with one compare channel and a waveform output. It advances only on a count-enable pulse. A select field picks that pulse from a divider tap of a free-running 10-bit prescaler on the system clock, or from rising edges of a second, unrelated clock input after a two-stage synchronizer. The same counter runs in one of four modes: a free-running count, an auto-reload count that restarts from zero after a compare match, a square-wave tone generator, and a dual-slope PWM source whose output cannot glitch.

Software loads the count and the compare value through write strobes. It reads back the count and the compare value in force. An overflow flag and a compare flag latch events until software writes a 1 to clear them. Each flag drives an interrupt request through its own mask bit. In PWM mode a new compare value waits in a shadow register and takes effect only when the count reaches its top value. A duty change therefore never lands in the middle of a period.

Top module: `tmr8_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `count`, `cmp_active`, `wave_out`, both flags and both interrupt requests are 0.
- R2: `clk_sel` sets the count enable. 0 stops the counter. 1 to 7 advance it once every 1, 8, 32, 64, 128, 256 or 1024 clock cycles. 8 advances it once per rising edge of `ext_clk`, after synchronization. Values 9 to 15 stop it.
- R3: A change of `clk_sel` restarts the prescaler, so the first advance at a divide of N comes N+1 clock edges after the edge that sees the new select.
- R4: Mode 0 (normal) counts up and wraps from 0xFF to 0x00 every 256 advances. The wrap sets `ovf_flag`.
- R5: Mode 1 (auto-reload) returns the count to 0x00 on the advance taken while the count equals the compare value, which gives a period of compare + 1 advances. `ovf_flag` is set only when the count passes 0xFF.
- R6: Mode 2 (tone) reloads the way mode 1 does and toggles `wave_out` on each compare match. The output therefore stays at one level for (compare + 1) × divide clock cycles.
- R7: Mode 3 (PWM) counts up to 0xFF and then down to 0x00, for a period of 510 advances. The advance that brings the count to 0x00 sets `ovf_flag`.
- R8: In mode 3, a match on the way up drives `wave_out` low and a match on the way down drives it high. A compare of 0x00 keeps it low and 0xFF keeps it high. It is high for 2 × compare advances per period.
- R9: In mode 3 a compare write goes to a shadow register, and `cmp_active` takes the shadow value on the advance taken at count 0xFF. In the other modes `cmp_active` takes the written value on the next clock.
- R10: A compare match sets `cmp_flag`. Writing 1 to `flag_clr` bit 0 clears `ovf_flag` and writing 1 to bit 1 clears `cmp_flag`. A new event in the same cycle takes precedence over the clear.
- R11: `irq_ovf` is `ovf_flag` gated by `irq_mask` bit 0, and `irq_cmp` is `cmp_flag` gated by bit 1.
- R12: `cnt_we` loads `cnt_wdata` into the count on the next clock, even while stopped. The advance that follows produces no compare match.
- R13: In modes 0 and 1 `wave_out` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 4 | Count-enable source select |
| ext_clk | input | 1 | Second clock source, asynchronous to `clk` |
| mode | input | 2 | 0 normal, 1 auto-reload, 2 tone, 3 PWM |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 compare |
| irq_mask | input | 2 | Interrupt enables: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current count |
| cmp_active | output | 8 | Compare value in force |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow event latched |
| cmp_flag | output | 1 | Compare event latched |
| irq_ovf | output | 1 | Masked overflow request |
| irq_cmp | output | 1 | Masked compare request |

## Verification
Several properties are checked on every cycle. A stopped counter holds its value. In PWM the overflow flag rises only with the count at zero. The PWM compare value changes only after a cycle at 0xFF. A compare flag rises only after the count equalled the compare value. The output stays low in the two non-waveform modes. Only the bench scenarios can show the quantities that span many cycles: wrap and toggle periods for each divider tap, PWM high time at the duty extremes, the prescaler restart, the external-edge count, and the blocked match after a count write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CNT_W     = 8;
    localparam int PRE_W_DEF = 10;
    localparam int SEL_W     = 4;
    localparam int SYNC_N    = 2;

    localparam logic [SEL_W-1:0] SEL_EXT = 4'd8;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_RELOAD = 2'd1,
        MODE_TONE   = 2'd2,
        MODE_PWM    = 2'd3
    } tmr_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
        logic             blk;
    } tmr_state_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } tmr_evt_t;

    // log2 of the divide ratio for each prescaler tap
    function automatic logic [3:0] tap_shift(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd1:    return 4'd0;
            4'd2:    return 4'd3;
            4'd3:    return 4'd5;
            4'd4:    return 4'd6;
            4'd5:    return 4'd7;
            4'd6:    return 4'd8;
            4'd7:    return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic sel_is_tap(input logic [SEL_W-1:0] sel);
        return (sel >= 4'd1) && (sel <= 4'd7);
    endfunction

endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel
    import tmr8_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_clk,
    output logic             tick
);
    localparam int EDGE_N = SYNC_N + 1;

    logic [PRE_W-1:0]  pre_q;
    logic [SEL_W-1:0]  sel_q;
    logic [EDGE_N-1:0] sync_q;
    logic [PRE_W-1:0]  tap_mask;
    logic              sel_chg;
    logic              ext_rise;

    assign sel_chg  = (sel != sel_q);
    assign tap_mask = ~({PRE_W{1'b1}} << tap_shift(sel));
    assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel;
            pre_q <= sel_chg ? '0 : pre_q + 1'b1;
        end
    end

    // synchronizer stages plus one edge-detect stage
    genvar g;
    generate
        for (g = 0; g < EDGE_N; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)         sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= ext_clk;
                else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        if (!sel_chg) begin
            if (sel_is_tap(sel))    tick = ((pre_q & tap_mask) == tap_mask);
            else if (sel == SEL_EXT) tick = ext_rise;
        end
    end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_act,
    output dir_e             dir,
    output logic             match,
    output tmr_evt_t         evt
);
    localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOT_V = '0;
    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_t       st_q, st_d;
    logic [CNT_W-1:0] shadow_q, act_q;
    logic             at_top, at_bot, hit;

    assign at_top = (st_q.cnt == TOP_V);
    assign at_bot = (st_q.cnt == BOT_V);
    assign hit    = (st_q.cnt == act_q);
    assign match  = tick & hit & ~st_q.blk & ~cnt_we;

    always_comb begin
        st_d = st_q;
        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
            st_d.blk = 1'b1;
        end else if (tick) begin
            st_d.blk = 1'b0;
            case (mode)
                MODE_NORMAL: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.dir = DIR_UP;
                end
                MODE_RELOAD, MODE_TONE: begin
                    st_d.cnt = hit ? BOT_V : st_q.cnt + 1'b1;
                    st_d.dir = DIR_UP;
                end
                default: begin
                    if (st_q.dir == DIR_UP) begin
                        st_d.cnt = at_top ? st_q.cnt - 1'b1 : st_q.cnt + 1'b1;
                        st_d.dir = at_top ? DIR_DOWN : DIR_UP;
                    end else begin
                        st_d.cnt = at_bot ? st_q.cnt + 1'b1 : st_q.cnt - 1'b1;
                        st_d.dir = at_bot ? DIR_UP : DIR_DOWN;
                    end
                end
            endcase
        end
    end

    always_comb begin
        evt.cmp = match;
        if (mode == MODE_PWM)
            evt.ovf = tick & ~cnt_we & (st_q.dir == DIR_DOWN) & (st_q.cnt == ONE_V);
        else
            evt.ovf = tick & ~cnt_we & at_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '{cnt: '0, dir: DIR_UP, blk: 1'b0};
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            st_q <= st_d;
            if (cmp_we) begin
                shadow_q <= cmp_wdata;
                if (mode != MODE_PWM) act_q <= cmp_wdata;
            end
            if (mode == MODE_PWM && tick && at_top && !cnt_we)
                act_q <= shadow_q;
        end
    end

    assign count   = st_q.cnt;
    assign cmp_act = act_q;
    assign dir     = st_q.dir;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  dir_e             dir,
    input  logic             match,
    input  logic [CNT_W-1:0] cmp_act,
    output logic             wave
);
    localparam logic [CNT_W-1:0] FULL_V = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else begin
            case (mode)
                MODE_TONE: begin
                    if (match) wave <= ~wave;
                end
                MODE_PWM: begin
                    if (tick) begin
                        if (cmp_act == '0)         wave <= 1'b0;
                        else if (cmp_act == FULL_V) wave <= 1'b1;
                        else if (match)             wave <= (dir == DIR_DOWN);
                    end
                end
                default: wave <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
    import tmr8_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ext_clk,
    input  logic [1:0]       mode,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       flag_clr,
    input  logic [1:0]       irq_mask,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_active,
    output logic             wave_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             irq_ovf,
    output logic             irq_cmp
);
    tmr_mode_e mode_e;
    logic      tick;
    logic      match;
    dir_e      dir;
    tmr_evt_t  evt;
    tmr_evt_t  flg_q;

    assign mode_e = tmr_mode_e'(mode);

    tmr8_clksel #(.PRE_W(PRE_W)) u_clksel (
        .clk     (clk),
        .rst     (rst),
        .sel     (clk_sel),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    tmr8_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (mode_e),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .count     (count),
        .cmp_act   (cmp_active),
        .dir       (dir),
        .match     (match),
        .evt       (evt)
    );

    tmr8_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode_e),
        .dir     (dir),
        .match   (match),
        .cmp_act (cmp_active),
        .wave    (wave_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q.ovf <= (flg_q.ovf & ~flag_clr[0]) | evt.ovf;
            flg_q.cmp <= (flg_q.cmp & ~flag_clr[1]) | evt.cmp;
        end
    end

    assign ovf_flag = flg_q.ovf;
    assign cmp_flag = flg_q.cmp;
    assign irq_ovf  = flg_q.ovf & irq_mask[0];
    assign irq_cmp  = flg_q.cmp & irq_mask[1];

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] clk_sel,
    input logic [1:0] mode,
    input logic       cnt_we,
    input logic [7:0] count,
    input logic [7:0] cmp_active,
    input logic       wave_out,
    input logic       ovf_flag,
    input logic       cmp_flag
);
    // R2: no count enable means no count change
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 4'd0 && !cnt_we) |=> $stable(count));

    // R4: a normal-mode wrap leaves the overflow flag set
    a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'd0 && $past(count) == 8'hFF && count == 8'h00 && !$past(cnt_we))
        |-> ovf_flag);

    // R7: in PWM the overflow flag rises only as the count lands on zero
    a_r7_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'd3 && $rose(ovf_flag)) |-> (count == 8'h00));

    // R9: in PWM the compare value in force moves only after a cycle at TOP
    a_r9_update_at_top: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'd3 && cmp_active != $past(cmp_active)) |-> ($past(count) == 8'hFF));

    // R10: the compare flag rises only after the count equalled the compare value
    a_r10_flag_from_match: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> ($past(count) == $past(cmp_active)));

    // R13: no waveform in normal and auto-reload modes
    a_r13_wave_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd1) |=> !wave_out);

endmodule

bind tmr8_timer tmr8_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_sel    (clk_sel),
    .mode       (mode),
    .cnt_we     (cnt_we),
    .count      (count),
    .cmp_active (cmp_active),
    .wave_out   (wave_out),
    .ovf_flag   (ovf_flag),
    .cmp_flag   (cmp_flag)
);

// File: tb/sim_tmr8_timer.sv
`timescale 1ns/1ps
module sim_tmr8_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] clk_sel = '0;
    logic       ext_clk = 1'b0;
    logic [1:0] mode = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic [1:0] flag_clr = '0;
    logic [1:0] irq_mask = '0;
    logic [7:0] count, cmp_active;
    logic       wave_out, ovf_flag, cmp_flag, irq_ovf, irq_cmp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr8_timer u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk(ext_clk), .mode(mode),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .flag_clr(flag_clr), .irq_mask(irq_mask), .count(count), .cmp_active(cmp_active),
        .wave_out(wave_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    // mode(2) sel(4) compare(8) wrap period(16) high cycles(16, FFFF = skip) ovf(1)
    localparam int NV = 14;
    localparam logic [46:0] VEC [0:NV-1] = '{
        {2'd0, 4'd1, 8'h10, 16'd256,  16'd0,      1'b1},
        {2'd0, 4'd2, 8'h10, 16'd2048, 16'd0,      1'b1},
        {2'd1, 4'd1, 8'h09, 16'd10,   16'd0,      1'b0},
        {2'd1, 4'd3, 8'h03, 16'd128,  16'd0,      1'b0},
        {2'd1, 4'd1, 8'hFF, 16'd256,  16'd0,      1'b1},
        {2'd1, 4'd4, 8'h03, 16'd256,  16'd0,      1'b0},
        {2'd1, 4'd5, 8'h01, 16'd256,  16'd0,      1'b0},
        {2'd1, 4'd6, 8'h01, 16'd512,  16'd0,      1'b0},
        {2'd1, 4'd7, 8'h01, 16'd2048, 16'd0,      1'b0},
        {2'd2, 4'd2, 8'h04, 16'd40,   16'hFFFF,   1'b0},
        {2'd3, 4'd1, 8'h40, 16'd510,  16'd128,    1'b1},
        {2'd3, 4'd1, 8'h00, 16'd510,  16'd0,      1'b1},
        {2'd3, 4'd1, 8'hFF, 16'd510,  16'd510,    1'b1},
        {2'd3, 4'd2, 8'h10, 16'd4080, 16'd256,    1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clk_sel = '0; ext_clk = 1'b0; mode = '0; cnt_we = 1'b0;
        cmp_we = 1'b0; flag_clr = '0; irq_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_wrap(output bit ok);
        logic [7:0] prev;
        prev = count;
        ok = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (prev != 8'h00 && count == 8'h00) begin ok = 1'b1; break; end
            prev = count;
        end
    endtask

    task automatic wave_gap(output int gap);
        logic prev;
        prev = wave_out;
        gap = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            gap++;
            if (wave_out != prev) break;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        bit ok;
        int per, hi, gap, c0;
        logic [7:0] prev;

        // R1: reset state, during and right after reset
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 cmp_active", cmp_active, 0);
        chk("R1 flags+wave+irq", {wave_out, ovf_flag, cmp_flag, irq_ovf, irq_cmp}, 0);

        // table walk: R2 taps, R4/R5/R6/R7 periods, R8 PWM high time
        for (int i = 0; i < NV; i++) begin
            do_reset();
            mode = VEC[i][46:45]; clk_sel = VEC[i][44:41];
            cmp_we = 1'b1; cmp_wdata = VEC[i][40:33];
            @(negedge clk);
            cmp_we = 1'b0;
            wait_wrap(ok);
            chk("R2 first wrap seen", ok, 1);
            hi = wave_out; per = 1; prev = count;
            for (int k = 0; k < 20000; k++) begin
                @(negedge clk);
                if (prev != 8'h00 && count == 8'h00) break;
                per++; hi += wave_out; prev = count;
            end
            chk($sformatf("R2 R4 R5 R7 period vec%0d", i), per, int'(VEC[i][32:17]));
            if (VEC[i][16:1] != 16'hFFFF)
                chk($sformatf("R8 R13 high cycles vec%0d", i), hi, int'(VEC[i][16:1]));
            chk($sformatf("R4 R5 R7 ovf_flag vec%0d", i), ovf_flag, int'(VEC[i][0]));
        end

        // R6: tone mode level time = (4+1)*8
        do_reset();
        mode = 2'd2; clk_sel = 4'd2; cmp_we = 1'b1; cmp_wdata = 8'h04;
        @(negedge clk); cmp_we = 1'b0;
        wave_gap(gap);
        wave_gap(gap);
        chk("R6 toggle spacing", gap, 40);
        wave_gap(gap);
        chk("R6 toggle spacing again", gap, 40);

        // R2: external source, 5 synchronized rising edges
        do_reset();
        clk_sel = 4'd8;
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        chk("R2 external edges counted", count, 5);
        // R2: select 0 freezes the count
        clk_sel = 4'd0;
        repeat (2) @(negedge clk);
        c0 = count;
        repeat (50) @(negedge clk);
        chk("R2 stopped count holds", count, c0);

        // R3: prescaler restarts on select change (divide 64)
        do_reset();
        clk_sel = 4'd2;
        repeat (13) @(negedge clk);
        clk_sel = 4'd4;
        c0 = count;
        repeat (64) @(negedge clk);
        chk("R3 no advance before 65th edge", count, c0);
        @(negedge clk);
        chk("R3 advance on 65th edge", count, (c0 + 1) & 8'hFF);

        // R12: count write blocks the next match; R10/R11 flags, masks, clear
        do_reset();
        cmp_we = 1'b1; cmp_wdata = 8'h20;
        @(negedge clk); cmp_we = 1'b0;
        clk_sel = 4'd1;
        repeat (3) @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = 8'h20;
        @(negedge clk); cnt_we = 1'b0;
        chk("R12 count loaded", count, 8'h20);
        repeat (5) @(negedge clk);
        chk("R12 match blocked after write", cmp_flag, 0);
        chk("R12 count runs on", count, 8'h25);
        repeat (260) @(negedge clk);
        clk_sel = 4'd0;
        @(negedge clk);
        chk("R10 compare flag set", cmp_flag, 1);
        chk("R4 overflow flag set", ovf_flag, 1);
        chk("R11 masked requests low", {irq_ovf, irq_cmp}, 0);
        irq_mask = 2'b10;
        @(negedge clk);
        chk("R11 compare request only", {irq_ovf, irq_cmp}, 2'b01);
        irq_mask = 2'b01;
        @(negedge clk);
        chk("R11 overflow request only", {irq_ovf, irq_cmp}, 2'b10);
        flag_clr = 2'b10;
        @(negedge clk); flag_clr = 2'b00;
        chk("R10 clear compare flag only", {ovf_flag, cmp_flag}, 2'b10);
        flag_clr = 2'b01;
        @(negedge clk); flag_clr = 2'b00;
        chk("R10 clear overflow flag", {ovf_flag, cmp_flag}, 2'b00);
        cnt_we = 1'b1; cnt_wdata = 8'h9C;
        @(negedge clk); cnt_we = 1'b0;
        chk("R12 write while stopped", count, 8'h9C);

        // R9: PWM compare waits for TOP; other modes take it at once
        do_reset();
        mode = 2'd3; clk_sel = 4'd1;
        repeat (20) @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = 8'h30;
        @(negedge clk); cmp_we = 1'b0;
        chk("R9 PWM write held in shadow", cmp_active, 0);
        for (int k = 0; k < 400; k++) begin
            if (count == 8'hFF) break;
            @(negedge clk);
        end
        chk("R9 still old at TOP", cmp_active, 0);
        @(negedge clk);
        chk("R9 shadow copied after TOP", cmp_active, 8'h30);
        mode = 2'd1; cmp_we = 1'b1; cmp_wdata = 8'h55;
        @(negedge clk); cmp_we = 1'b0;
        chk("R9 immediate in auto-reload", cmp_active, 8'h55);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule